// File: doc/BRIEF.md
# Parameterised ALU with Per-Nibble Carry Flags

This block is a purely combinational arithmetic-logic unit for a small microcontroller-style datapath. It takes two operands of `W` bits, an incoming carry-flag vector, an incoming overflow flag and a 3-bit operation code. It returns a `W`-bit result, an updated carry vector, an updated overflow flag and a `2*W`-bit product.

The carry flag is a vector with one bit per 4-bit nibble boundary, not a single bit. Its most significant bit is the carry out of the whole word. The lower bits serve as half-carry style flags for the nibble boundaries below it. Each operation class has its own flag rule:

- Logic operations leave every flag untouched.
- The two additions recompute all carries and the overflow flag.
- Multiply rewrites only the word carry and the overflow flag.

The surrounding sequencer registers the outputs.

Top module: `nibble_alu`

## Requirements
- R1: The operation code `op_sel` is decoded as follows: 0 = AND, 1 = OR, 2 = XOR, 3 = ADD, 4 = ADD-with-carry, 5 = MUL. For codes 6 and 7 the result is 0 and the product is 0. For those codes `cy_out` equals `cy_in` and `ov_out` equals `ov_in`.
- R2: For codes 0, 1 and 2 the result is the bitwise AND, OR or XOR of the operands. For these codes `cy_out` equals `cy_in`, `ov_out` equals `ov_in`, and the product is 0.
- R3: For code 3 the result is `(a+b) mod 2^W`. The carry vector has `CW = (W-1)/4+1` bits. For each `h < CW-1`, bit `h` is set exactly when the sum of the low `4*(h+1)` bits of both operands needs more than `4*(h+1)` bits. Bit `CW-1` is the carry out of bit `W-1`.
- R4: For code 4 the carry-in is `cy_in[CW-1]`. This carry-in is added into the result and into every carry bit described in R3.
- R5: For codes 3 and 4, `ov_out` is set exactly when the word carry differs from the carry into bit `W-1`. The carry into bit `W-1` comes from adding the low `W-1` bits of both operands plus any carry-in.
- R6: For code 5 the product is the unsigned `a*b` over `2*W` bits. The result is the low `W` bits of that product.
- R7: For code 5, `ov_out` is set exactly when the product exceeds `2^W-1`. `cy_out[CW-1]` is 0, and the lower carry bits equal the matching bits of `cy_in`.
- R8: When `W` is 4 or less, the carry vector is a single bit. That bit acts as both the nibble carry and the word carry.
- R9: The product output is 0 for every code other than 5.
- R10: All outputs depend only on the present inputs. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| cy_in | input | CW | Incoming carry vector (bit CW-1 = word carry) |
| ov_in | input | 1 | Incoming overflow flag |
| op_sel | input | 3 | Operation code |
| result | output | W | Operation result |
| cy_out | output | CW | Updated carry vector |
| ov_out | output | 1 | Updated overflow flag |
| product | output | 2*W | Double-width product (MUL only) |

## Verification
The bench sweeps every operand pair, every carry/overflow input and every operation code for a 6-bit instance, which has two carry bits, and for a 3-bit instance, which has one carry bit. Expected values come from integer arithmetic.

The sweep targets these corner cases:

- **Word carry vs. nibble carry.** A design that takes the top carry from a nibble boundary instead of the word edge gives wrong flags at `W=6`.
- **Carry-in reach.** A design that feeds the ADD-with-carry carry-in into the result but not into the nibble carries is caught on the low-nibble flag.
- **Overflow source.** A design that computes overflow from the operand signs alone, rather than from the carry into the MSB, fails on sums such as `0x1F+0x01`.
- **Multiply flags.** A multiply that clears the lower carry bits, or leaves a stale word carry, is reported.
- **Unused codes.** A decoder that lets codes 6 and 7 alias onto a real operation is also reported.

// File: rtl/nibble_alu_pkg.sv
`timescale 1ns/1ps
package nibble_alu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_ADD  = 3'd3,
        OP_ADDC = 3'd4,
        OP_MUL  = 3'd5
    } alu_op_e;

    function automatic int unsigned carry_bits(int unsigned w);
        return (w - 1) / 4 + 1;
    endfunction

endpackage

// File: rtl/nibble_alu_logic.sv
`timescale 1ns/1ps
module nibble_alu_logic #(
    parameter int unsigned W = 8
) (
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] logic_res
);
    import nibble_alu_pkg::*;

    always_comb begin
        unique case (op_sel)
            OP_AND:  logic_res = opnd_a & opnd_b;
            OP_OR:   logic_res = opnd_a | opnd_b;
            OP_XOR:  logic_res = opnd_a ^ opnd_b;
            default: logic_res = '0;
        endcase
    end
endmodule

// File: rtl/nibble_alu_adder.sv
`timescale 1ns/1ps
module nibble_alu_adder #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = 2
) (
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic          carry_in,
    output logic [W-1:0]  sum,
    output logic [CW-1:0] carries,
    output logic          ovf
);
    logic [W:0]   full_sum;
    logic [W-1:0] into_bit;   // carry entering each bit position

    assign full_sum = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_in};
    assign into_bit = full_sum[W-1:0] ^ opnd_a ^ opnd_b;
    assign sum      = full_sum[W-1:0];

    // Nibble boundaries below the word edge: carry out of bit 4*(h+1)-1
    // is the carry entering bit 4*(h+1).
    for (genvar h = 0; h < CW - 1; h++) begin : g_nib
        assign carries[h] = into_bit[4*(h+1)];
    end
    assign carries[CW-1] = full_sum[W];

    assign ovf = full_sum[W] ^ into_bit[W-1];
endmodule

// File: rtl/nibble_alu_mult.sv
`timescale 1ns/1ps
module nibble_alu_mult #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [2*W-1:0] prod,
    output logic           hi_nonzero
);
    localparam int unsigned PW = 2 * W;

    assign prod       = PW'(opnd_a) * PW'(opnd_b);
    assign hi_nonzero = |prod[PW-1:W];
endmodule

// File: rtl/nibble_alu.sv
`timescale 1ns/1ps
module nibble_alu #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]                           opnd_a,
    input  logic [W-1:0]                           opnd_b,
    input  logic [nibble_alu_pkg::carry_bits(W)-1:0] cy_in,
    input  logic                                   ov_in,
    input  logic [2:0]                             op_sel,
    output logic [W-1:0]                           result,
    output logic [nibble_alu_pkg::carry_bits(W)-1:0] cy_out,
    output logic                                   ov_out,
    output logic [2*W-1:0]                         product
);
    import nibble_alu_pkg::*;

    localparam int unsigned CW = carry_bits(W);
    localparam int unsigned PW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  res;
        logic [CW-1:0] cy;
        logic          ov;
        logic [PW-1:0] prod;
    } alu_out_t;

    alu_out_t      out_d;
    logic [W-1:0]  logic_res;
    logic [W-1:0]  add_sum;
    logic [CW-1:0] add_cy;
    logic          add_ov;
    logic          add_cin;
    logic [PW-1:0] mul_prod;
    logic          mul_hi;

    assign add_cin = (op_sel == OP_ADDC) & cy_in[CW-1];

    nibble_alu_logic #(.W(W)) i_logic (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .logic_res (logic_res)
    );

    nibble_alu_adder #(.W(W), .CW(CW)) i_adder (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .carry_in (add_cin),
        .sum      (add_sum),
        .carries  (add_cy),
        .ovf      (add_ov)
    );

    nibble_alu_mult #(.W(W)) i_mult (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .prod       (mul_prod),
        .hi_nonzero (mul_hi)
    );

    always_comb begin
        out_d.res  = '0;
        out_d.cy   = cy_in;
        out_d.ov   = ov_in;
        out_d.prod = '0;
        unique case (op_sel)
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res = logic_res;
            end
            OP_ADD, OP_ADDC: begin
                out_d.res = add_sum;
                out_d.cy  = add_cy;
                out_d.ov  = add_ov;
            end
            OP_MUL: begin
                out_d.res       = mul_prod[W-1:0];
                out_d.prod      = mul_prod;
                out_d.ov        = mul_hi;
                out_d.cy[CW-1]  = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign result  = out_d.res;
    assign cy_out  = out_d.cy;
    assign ov_out  = out_d.ov;
    assign product = out_d.prod;
endmodule

// File: rtl/nibble_alu_chk.sv
`timescale 1ns/1ps
module nibble_alu_chk #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = 2
) (
    input logic [W-1:0]   opnd_a,
    input logic [W-1:0]   opnd_b,
    input logic [CW-1:0]  cy_in,
    input logic           ov_in,
    input logic [2:0]     op_sel,
    input logic [W-1:0]   result,
    input logic [CW-1:0]  cy_out,
    input logic           ov_out,
    input logic [2*W-1:0] product
);
    logic       known;
    logic [W:0] plain_sum;

    assign known     = !$isunknown({opnd_a, opnd_b, cy_in, ov_in, op_sel});
    assign plain_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

    always_comb begin
        if (known) begin
            p_unused_zero_r1: assert (!(op_sel > 3'd5) ||
                                      (result == '0 && product == '0 &&
                                       cy_out == cy_in && ov_out == ov_in))
                else $error("unused code altered outputs");
            p_logic_flags_r2: assert (!(op_sel <= 3'd2) ||
                                      (cy_out == cy_in && ov_out == ov_in))
                else $error("logic op changed flags");
            p_add_word_r3: assert (!(op_sel == 3'd3) ||
                                   ({cy_out[CW-1], result} == plain_sum))
                else $error("ADD result or word carry wrong");
            p_mul_flags_r7: assert (!(op_sel == 3'd5) ||
                                    (cy_out[CW-1] == 1'b0 &&
                                     ov_out == (product > {{W{1'b0}}, {W{1'b1}}})))
                else $error("MUL flags wrong");
            p_mul_low_r6: assert (!(op_sel == 3'd5) || result == product[W-1:0])
                else $error("MUL result not low product half");
            p_prod_zero_r9: assert (op_sel == 3'd5 || product == '0)
                else $error("product nonzero outside MUL");
        end
    end
endmodule

bind nibble_alu nibble_alu_chk #(.W(W), .CW(CW)) i_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .cy_in   (cy_in),
    .ov_in   (ov_in),
    .op_sel  (op_sel),
    .result  (result),
    .cy_out  (cy_out),
    .ov_out  (ov_out),
    .product (product)
);

// File: tb/test_nibble_alu.sv
`timescale 1ns/1ps
module test_nibble_alu;

    localparam int WA  = 6;
    localparam int CWA = (WA - 1) / 4 + 1;
    localparam int WB  = 3;
    localparam int CWB = (WB - 1) / 4 + 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // wide instance (two carry bits)
    logic [WA-1:0]   a_a, a_b, a_res;
    logic [CWA-1:0]  a_cyi, a_cyo;
    logic            a_ovi, a_ovo;
    logic [2:0]      a_op;
    logic [2*WA-1:0] a_prod;

    // narrow instance (single carry bit, R8)
    logic [WB-1:0]   b_a, b_b, b_res;
    logic [CWB-1:0]  b_cyi, b_cyo;
    logic            b_ovi, b_ovo;
    logic [2:0]      b_op;
    logic [2*WB-1:0] b_prod;

    nibble_alu #(.W(WA)) i_nibble_alu (
        .opnd_a(a_a), .opnd_b(a_b), .cy_in(a_cyi), .ov_in(a_ovi), .op_sel(a_op),
        .result(a_res), .cy_out(a_cyo), .ov_out(a_ovo), .product(a_prod)
    );

    nibble_alu #(.W(WB)) i_nibble_alu_w3 (
        .opnd_a(b_a), .opnd_b(b_b), .cy_in(b_cyi), .ov_in(b_ovi), .op_sel(b_op),
        .result(b_res), .cy_out(b_cyo), .ov_out(b_ovo), .product(b_prod)
    );

    function automatic string req_tag(int op);
        case (op)
            0, 1, 2: return "R2";
            3:       return "R3/R5";
            4:       return "R4/R5";
            5:       return "R6/R7";
            default: return "R1/R9";
        endcase
    endfunction

    // Arithmetic model written from the requirements.
    function automatic void model(input int w, input int op, input int a, input int b,
                                  input int cy, input int ov,
                                  output int r, output int c, output int o, output int p);
        int cw, mask, cin, wh, m, cout, cm;
        cw   = (w - 1) / 4 + 1;
        mask = (1 << w) - 1;
        r = 0; c = cy; o = ov; p = 0;
        case (op)
            0: r = a & b;
            1: r = a | b;
            2: r = a ^ b;
            3, 4: begin
                cin = (op == 4) ? ((cy >> (cw - 1)) & 1) : 0;
                r = (a + b + cin) & mask;
                c = 0;
                for (int h = 0; h < cw; h++) begin
                    wh = (h == cw - 1) ? w : 4 * (h + 1);
                    if ((a % (1 << wh)) + (b % (1 << wh)) + cin >= (1 << wh))
                        c = c | (1 << h);
                end
                cout = (c >> (cw - 1)) & 1;
                m  = w - 1;
                cm = ((a % (1 << m)) + (b % (1 << m)) + cin >= (1 << m)) ? 1 : 0;
                o  = cout ^ cm;
            end
            5: begin
                p = a * b;
                r = p & mask;
                o = (p > mask) ? 1 : 0;
                c = cy & ~(1 << (cw - 1));
            end
            default: ;
        endcase
    endfunction

    task automatic compare(input string inst, input int op, input int a, input int b,
                           input int cy, input int ov,
                           input int gr, input int gc, input int go, input int gp,
                           input int w);
        int er, ec, eo, ep;
        model(w, op, a, b, cy, ov, er, ec, eo, ep);
        checks++;
        if (gr != er || gc != ec || go != eo || gp != ep) begin
            errors++;
            if (errors <= 20)
                $display("FAIL %s %s op=%0d a=%0d b=%0d cy=%0d ov=%0d: got res=%0d cy=%0d ov=%0d prod=%0d, expected res=%0d cy=%0d ov=%0d prod=%0d",
                         req_tag(op), inst, op, a, b, cy, ov, gr, gc, go, gp, er, ec, eo, ep);
        end
    endtask

    initial begin
        a_a = '0; a_b = '0; a_cyi = '0; a_ovi = 1'b0; a_op = 3'd0;
        b_a = '0; b_b = '0; b_cyi = '0; b_ovi = 1'b0; b_op = 3'd0;
        #1;
        // initial state: all-zero inputs give all-zero outputs (R10)
        checks++;
        if (a_res != 0 || a_cyo != 0 || a_ovo != 0 || a_prod != 0) begin
            errors++;
            $display("FAIL R10 initial outputs res=%0d cy=%0d ov=%0d prod=%0d, expected all 0",
                     a_res, a_cyo, a_ovo, a_prod);
        end

        // Exhaustive sweep, W=6: covers R1..R7, R9, R10
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < (1 << WA); a++)
                for (int b = 0; b < (1 << WA); b++)
                    for (int f = 0; f < (1 << (CWA + 1)); f++) begin
                        a_op  = 3'(op);
                        a_a   = WA'(a);
                        a_b   = WA'(b);
                        a_cyi = CWA'(f);
                        a_ovi = f[CWA];
                        #1;
                        compare("W6", op, a, b, f % (1 << CWA), (f >> CWA) & 1,
                                int'(a_res), int'(a_cyo), int'(a_ovo), int'(a_prod), WA);
                    end

        // Exhaustive sweep, W=3: single-bit carry vector (R8)
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < (1 << WB); a++)
                for (int b = 0; b < (1 << WB); b++)
                    for (int f = 0; f < (1 << (CWB + 1)); f++) begin
                        b_op  = 3'(op);
                        b_a   = WB'(a);
                        b_b   = WB'(b);
                        b_cyi = CWB'(f);
                        b_ovi = f[CWB];
                        #1;
                        compare("W3 R8", op, a, b, f % (1 << CWB), (f >> CWB) & 1,
                                int'(b_res), int'(b_cyo), int'(b_ovo), int'(b_prod), WB);
                    end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, got %0d cycles, expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule